// File: doc/BRIEF.md
# Missed-Tick Watchdog with Byte Register Window

This peripheral watches for a stalled processor. Software reaches it through a byte-wide register window of 16 locations. The interface is synchronous and carries an address, write data, a write strobe, a read strobe and read data.

Once software enables the block, it evaluates at a fixed period. Each evaluation checks whether software has kicked the block since the previous evaluation. If it has not, a miss counter advances. Software keeps the system alive by writing the kick location at least once per period.

When the count of consecutive misses passes one, the block emits a warning pulse. When the count passes a configurable limit, it emits a reset-request pulse, which the system reset logic is expected to act upon. A prescaler derives the evaluation period from the clock. Its length is a parameter, so one build can use a one-second period and another a short period.

Top module: `tick_miss_watchdog`

## Requirements
- R1: Offset 0x0 reads as 0x42 at all times; writes to it change nothing.
- R2: A write to offset 0x1 sets the enable flag to 1 when the data is non-zero and to 0 when it is zero. Offset 0x1 reads as 0x00 or 0x01 to match the flag.
- R3: A write of any value to offset 0x2 (a kick) sets the kicked flag and clears the miss counter. If a kick and a periodic evaluation fall on the same edge, the kick wins and that evaluation is dropped.
- R4: At each evaluation, the miss counter advances by one if the kicked flag is clear. The kicked flag is cleared afterwards in either case.
- R5: `warn_o` pulses when the miss counter, after an evaluation, is greater than 1.
- R6: `reset_req_o` pulses when the miss counter, after an evaluation, is strictly greater than `EXPIRE_LIMIT` (default 10).
- R7: Every write of a non-zero value to offset 0x1 triggers one evaluation at that edge and restarts the prescaler. While the block stays enabled, further evaluations follow every `TICK_CYCLES` clock cycles.
- R8: While the block is disabled, no evaluation takes place, and disabling it cancels the evaluation in progress. The miss counter and the kicked flag keep their values across a disable.
- R9: Reset clears the enable flag, the kicked flag and the miss counter, and holds both pulse outputs low.
- R10: Offsets 0x3 to 0xF read as 0x00, and writes to them change nothing.
- R11: Each pulse lasts exactly one clock cycle, in the cycle after the edge of the evaluation that caused it. Read data appears in the cycle after the read strobe.
- R12: The miss counter saturates at its maximum value instead of wrapping, so `reset_req_o` keeps pulsing at every unkicked evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| addr_i | input | 4 | Register offset |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, valid the cycle after `rd_en_i` |
| warn_o | output | 1 | One-cycle warning pulse |
| reset_req_o | output | 1 | One-cycle system-reset request pulse |

## Verification
The bench builds the block with `TICK_CYCLES` = 5 and `EXPIRE_LIMIT` = 3. With these values the warning point, the limit crossing and counter saturation (the 3-bit counter tops out at 7) all fall within a few dozen evaluations. The short period also lets the bench compare both pulse outputs against an arithmetic prediction on every cycle. It sweeps all 13 unused offsets and all 255 non-zero enable values. It also places a kick on the exact edge of a periodic evaluation to check which one wins.

// File: rtl/tmw_pkg.sv
package tmw_pkg;

  localparam logic [7:0] TMW_ID_VALUE = 8'h42;

  localparam logic [3:0] OFS_ID   = 4'h0;
  localparam logic [3:0] OFS_EN   = 4'h1;
  localparam logic [3:0] OFS_KICK = 4'h2;

  typedef struct packed {
    logic en_set;   // non-zero write to enable location
    logic en_clr;   // zero write to enable location
    logic kick;     // any write to kick location
  } tmw_cmd_t;

endpackage

// File: rtl/tmw_rst_sync.sv
module tmw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/tmw_regs.sv
module tmw_regs
  import tmw_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              en_o,
  output tmw_cmd_t          cmd_o
);

  localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(OFS_ID);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);
  localparam logic [ADDR_W-1:0] A_KICK = ADDR_W'(OFS_KICK);

  logic              en_q, en_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [DATA_W-1:0] rd_mux;
  tmw_cmd_t          cmd;

  always_comb begin
    cmd.en_set = wr_en_i && (addr_i == A_EN) && (|wdata_i);
    cmd.en_clr = wr_en_i && (addr_i == A_EN) && !(|wdata_i);
    cmd.kick   = wr_en_i && (addr_i == A_KICK);
  end

  always_comb begin
    en_d = en_q;
    if (cmd.en_set)      en_d = 1'b1;
    else if (cmd.en_clr) en_d = 1'b0;
  end

  always_comb begin
    unique case (addr_i)
      A_ID:    rd_mux = DATA_W'(TMW_ID_VALUE);
      A_EN:    rd_mux = DATA_W'(en_q);
      default: rd_mux = '0;
    endcase
    rdata_d = rd_en_i ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      en_q    <= en_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;
  assign en_o    = en_q;
  assign cmd_o   = cmd;

  AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == A_ID) |=> (rdata_o == DATA_W'(TMW_ID_VALUE))); // R1

  AST_UNUSED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i > A_KICK) |=> (rdata_o == '0)); // R10

  AST_EN_READ_BINARY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == A_EN) |=> (rdata_o <= DATA_W'(1))); // R2

endmodule

// File: rtl/tmw_prescaler.sv
module tmw_prescaler #(
  parameter int unsigned TICK_CYCLES = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic restart_i,
  input  logic stop_i,
  output logic tick_o
);

  localparam int unsigned PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic          at_last;
  logic          tick;

  always_comb begin
    at_last = (pre_q == LAST);
    tick    = run_i && !stop_i && !restart_i && at_last;
    if (restart_i || stop_i || !run_i || at_last) pre_d = '0;
    else                                          pre_d = pre_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick_o = tick;

  generate
    if (TICK_CYCLES > 1) begin : g_period_chk
      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R7
    end
  endgenerate

endmodule

// File: rtl/tmw_miss_ctr.sv
module tmw_miss_ctr #(
  parameter int unsigned EXPIRE_LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic eval_i,
  input  logic kick_i,
  output logic warn_o,
  output logic reset_req_o
);

  localparam int unsigned CW = $clog2(EXPIRE_LIMIT + 2);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam logic [CW-1:0] CLIM = CW'(EXPIRE_LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          kicked_q, kicked_d;
  logic          warn_q, warn_d;
  logic          req_q, req_d;

  always_comb begin
    cnt_d    = cnt_q;
    kicked_d = kicked_q;
    warn_d   = 1'b0;
    req_d    = 1'b0;
    if (kick_i) begin
      kicked_d = 1'b1;
      cnt_d    = '0;
    end else if (eval_i) begin
      if (!kicked_q && cnt_q != CMAX) cnt_d = cnt_q + CW'(1);
      kicked_d = 1'b0;
      warn_d   = (cnt_d > CW'(1));
      req_d    = (cnt_d > CLIM);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      kicked_q <= 1'b0;
      warn_q   <= 1'b0;
      req_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      kicked_q <= kicked_d;
      warn_q   <= warn_d;
      req_q    <= req_d;
    end
  end

  assign warn_o      = warn_q;
  assign reset_req_o = req_q;

  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> (cnt_q == '0 && kicked_q)); // R3

  AST_WARN_ABOVE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    warn_q |-> (cnt_q > CW'(1))); // R5

  AST_REQ_ABOVE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |-> (cnt_q > CLIM)); // R6

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CMAX && !kick_i) |=> (cnt_q == CMAX)); // R12

  AST_EVAL_CLEARS_KICKED: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && !kick_i) |=> !kicked_q); // R4

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_req_o && !$past(eval_i && !kick_i)) |-> 1'b0); // R11

endmodule

// File: rtl/tick_miss_watchdog.sv
module tick_miss_watchdog
  import tmw_pkg::*;
#(
  parameter int unsigned ADDR_W       = 4,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned TICK_CYCLES  = 100_000_000,
  parameter int unsigned EXPIRE_LIMIT = 10,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              warn_o,
  output logic              reset_req_o
);

  logic     rst_sync_n;
  logic     en;
  tmw_cmd_t cmd;
  logic     tick;
  logic     eval;

  tmw_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_sync_n_o (rst_sync_n)
  );

  tmw_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .rdata_o (rdata_o),
    .en_o    (en),
    .cmd_o   (cmd)
  );

  tmw_prescaler #(.TICK_CYCLES(TICK_CYCLES)) i_prescaler (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .run_i     (en),
    .restart_i (cmd.en_set),
    .stop_i    (cmd.en_clr),
    .tick_o    (tick)
  );

  assign eval = cmd.en_set | tick;

  tmw_miss_ctr #(.EXPIRE_LIMIT(EXPIRE_LIMIT)) i_miss_ctr (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .eval_i      (eval),
    .kick_i      (cmd.kick),
    .warn_o      (warn_o),
    .reset_req_o (reset_req_o)
  );

  AST_NO_EVAL_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!en && !cmd.en_set) |-> !tick); // R8

  AST_REQ_IMPLIES_WARN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reset_req_o |-> warn_o); // R6

endmodule

// File: tb/test_tick_miss_watchdog.sv
module test_tick_miss_watchdog;

  localparam int N   = 5;
  localparam int LIM = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] addr;
  logic [7:0] wdata;
  logic       wr_en, rd_en;
  logic [7:0] rdata;
  logic       warn, rreq;

  int errors = 0;
  int checks = 0;
  int m_cnt;
  bit m_kicked;

  always #5 clk = ~clk;

  tick_miss_watchdog #(.TICK_CYCLES(N), .EXPIRE_LIMIT(LIM)) i_tick_miss_watchdog (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .rdata_o(rdata),
    .warn_o(warn), .reset_req_o(rreq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_cnt = 0; m_kicked = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  // Per-cycle comparison of both pulses after an enable write (t=0 is the
  // cycle after the enabling edge). Covers R4 R5 R6 R7 R11 R12.
  task automatic watch(input int cycles, input int kick_t);
    bit skip = 0;
    for (int t = 0; t < cycles; t++) begin
      bit ev, ew, er;
      ev = (t % N == 0) && !skip;
      if (t % N == 0) skip = 0;
      ew = 0; er = 0;
      if (ev) begin
        if (!m_kicked && m_cnt < 1000) m_cnt++;
        m_kicked = 0;
        ew = (m_cnt > 1);
        er = (m_cnt > LIM);
      end
      chk(warn == ew, $sformatf("R5 warn t=%0d", t), warn, ew);
      chk(rreq == er, $sformatf("R6 reset_req t=%0d", t), rreq, er);
      if (t == kick_t) begin
        addr = 4'h2; wdata = 8'h5A; wr_en = 1'b1;
        m_kicked = 1; m_cnt = 0;
        if ((t + 1) % N == 0) skip = 1;   // R3 kick beats evaluation
      end else begin
        wr_en = 1'b0;
      end
      @(posedge clk); @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  task automatic idle_watch(input int cycles, input string tag);
    for (int t = 0; t < cycles; t++) begin
      chk(warn == 1'b0, {tag, " warn idle"}, warn, 0);
      chk(rreq == 1'b0, {tag, " reset_req idle"}, rreq, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=hung exp=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    do_reset();

    // R9 reset state
    chk(warn == 0 && rreq == 0, "R9 pulses low after reset", {warn, rreq}, 0);
    rd(4'h0, d); chk(d == 8'h42, "R1 id read", d, 8'h42);
    rd(4'h1, d); chk(d == 8'h00, "R9 enable clear after reset", d, 0);

    // R1 write to id ignored
    wr(4'h0, 8'h5A);
    rd(4'h0, d); chk(d == 8'h42, "R1 id after write", d, 8'h42);

    // R10 unused offsets sweep
    for (int a = 3; a < 16; a++) begin
      wr(4'(a), 8'hFF);
      rd(4'(a), d); chk(d == 8'h00, $sformatf("R10 offset %0d", a), d, 0);
    end
    rd(4'h1, d); chk(d == 8'h00, "R10 enable untouched", d, 0);
    rd(4'h0, d); chk(d == 8'h42, "R10 id untouched", d, 8'h42);
    idle_watch(3 * N, "R10");

    // Scenario A: no kicks, into saturation (R4 R5 R6 R7 R11 R12)
    wr(4'h1, 8'h03);
    watch((LIM + 10) * N, -1);

    // R8 disable holds off evaluations
    wr(4'h1, 8'h00);
    rd(4'h1, d); chk(d == 8'h00, "R2 enable cleared by zero write", d, 0);
    idle_watch(4 * N, "R8");

    // Re-enable: immediate evaluation with held count (R7 R8), kick (R3)
    wr(4'h1, 8'h80);
    watch(4 * N, 1);

    // R9 reset mid-run
    do_reset();
    rd(4'h1, d); chk(d == 8'h00, "R9 enable cleared by reset", d, 0);
    idle_watch(3 * N, "R9");

    // R2 sweep of all non-zero enable values
    for (int v = 1; v < 256; v++) begin
      wr(4'h1, 8'(v));
      rd(4'h1, d); chk(d == 8'h01, $sformatf("R2 enable value %0d", v), d, 1);
    end
    wr(4'h1, 8'h00);
    rd(4'h1, d); chk(d == 8'h00, "R2 zero write", d, 0);

    // Scenario B: one kick in the first period (R3 R4)
    do_reset();
    wr(4'h1, 8'h01);
    watch(9 * N, 2);

    // Scenario C: kick on the edge of a periodic evaluation (R3)
    do_reset();
    wr(4'h1, 8'h01);
    watch(9 * N, N - 1);
    wr(4'h1, 8'h00);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule